// File: doc/BRIEF.md
# Tagged Circular Register Stack

The block is an eight-entry file of 80-bit extended-precision values. It can be used both as a push-down stack and as a set of registers addressed relative to a wrapping 3-bit top pointer. Position `i` names physical register (top + i) mod 8, and position 0 is the top.

Each physical register carries a 2-bit class tag. The tag is derived from the value whenever the register is written. It is forced to empty when the register is popped or explicitly freed.

A host execution unit uses the block for stack push and pop, for relative reads and writes of operands, and for restoring a saved environment by loading the tag word and the top pointer directly. Two sticky flags report pushes onto an occupied register and reads of empty positions.

Top module: `tagStack`

## Requirements
- R1: After reset, `top` is 0, `tagWord` reads 0xFFFF (every tag empty), and both `overflow` and `underflow` are 0.
- R2: A register write sets that register's tag from the 80-bit value. The value layout is sign at bit 79, exponent at bits 78:64 and significand at bits 63:0, with the explicit integer bit at bit 63. The tag codes are:
  - 01 (zero) when the exponent and significand are both zero.
  - 10 (special) when the exponent is all ones.
  - 10 (special) when the exponent is zero and the significand is nonzero.
  - 10 (special) when the exponent is nonzero and bit 63 is clear.
  - 00 (valid) in every other case.
  - 11 means empty.
  - The tag of physical register k sits at `tagWord` bits 2k+1:2k.
- R3: A successful push moves `top` to (top − 1) mod 8 at the clock edge and stores `pushData` in that register. The stored value then reads back as position 0.
- R4: While `popEn` is high, `popData` shows the value of the current top register in the same cycle. At the edge, `top` becomes (top + 1) mod 8.
- R5: `rdData` shows physical register (top + `rdIdx`) mod 8 without a clock delay. When a push happens in the same cycle, the read uses the top value from before the push.
- R6: A pop sets the tag of the popped register to 11. A free command sets the tag of position `freeIdx` to 11. In both cases the register contents are kept.
- R7: A relative write stores `wrData` into position `wrIdx` and tags it according to R2.
- R8: A push whose target register is not empty sets `overflow`. That push writes nothing and leaves `top` and `tagWord` unchanged.
- R9: `underflow` is set in two cases:
  - a read (`rdEn`) of a position whose tag is 11;
  - a pop of an empty top, which still advances `top`.
- R10: Both flags stay set until `flagClr` is asserted. If a flag is set and cleared in the same cycle, the set wins.
- R11: `tagLoadEn` replaces the whole tag word, and `topLoadEn` replaces `top`, at the next edge. In a cycle with either load, push, pop, write and free have no effect.
- R12: When several commands are raised together, only one is executed. The order is push first, then pop, then write, then free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Push command |
| pushData | input | 80 | Value to push |
| popEn | input | 1 | Pop command |
| popData | output | 80 | Current top value |
| rdEn | input | 1 | Relative read strobe, used for underflow detection |
| rdIdx | input | 3 | Relative read position |
| rdData | output | 80 | Value at relative read position |
| wrEn | input | 1 | Relative write command |
| wrIdx | input | 3 | Relative write position |
| wrData | input | 80 | Value to write |
| freeEn | input | 1 | Free command |
| freeIdx | input | 3 | Relative position to free |
| tagLoadEn | input | 1 | Load the tag word |
| tagLoadData | input | 16 | Tag word to load |
| topLoadEn | input | 1 | Load the top pointer |
| topLoadData | input | 3 | Top value to load |
| flagClr | input | 1 | Clear both flags |
| tagWord | output | 16 | Packed physical tags |
| top | output | 3 | Top-of-stack pointer |
| overflow | output | 1 | Sticky overflow flag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block at its fixed shape of eight 80-bit registers with a 15-bit exponent. With that shape, a single push from reset already wraps `top` from 0 to 7, and a second pop wraps it back up through 0. Relative positions therefore cross the physical index boundary within a few cycles. Five pushes of hand-built values cover every tag class, including the unnormal case where only the integer bit separates valid from special.

// File: rtl/tagStackPkg.sv
package tagStackPkg;
  localparam int NREG  = 8;
  localparam int PTR_W = $clog2(NREG);
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int VAL_W = 1 + EXP_W + MAN_W;
  localparam int TW_W  = 2 * NREG;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tagE;

  typedef struct packed {
    logic             wrStb;
    logic             selPush;
    logic [PTR_W-1:0] wrAddr;
  } dpStrobeT;

  function automatic tagE classify(input logic [VAL_W-1:0] v);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    ex = v[VAL_W-2 -: EXP_W];
    mn = v[MAN_W-1:0];
    if (ex == '0 && mn == '0) return TAG_ZERO;
    else if (ex == '1)        return TAG_SPECIAL;
    else if (ex == '0)        return TAG_SPECIAL;
    else if (!mn[MAN_W-1])    return TAG_SPECIAL;
    else                      return TAG_VALID;
  endfunction
endpackage

// File: rtl/tagStackCtrl.sv
module tagStackCtrl
  import tagStackPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [VAL_W-1:0] pushData,
  input  logic             popEn,
  input  logic             rdEn,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic             wrEn,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [VAL_W-1:0] wrData,
  input  logic             freeEn,
  input  logic [PTR_W-1:0] freeIdx,
  input  logic             tagLoadEn,
  input  logic [TW_W-1:0]  tagLoadData,
  input  logic             topLoadEn,
  input  logic [PTR_W-1:0] topLoadData,
  input  logic             flagClr,
  output dpStrobeT         strb,
  output logic [PTR_W-1:0] topQ,
  output logic [TW_W-1:0]  tagWord,
  output logic             ovfQ,
  output logic             unfQ
);
  tagE tagQ [NREG];

  logic             loadCycle, pushOk, doPop, doWr, doFree, ovfSet, unfSet;
  logic [PTR_W-1:0] pushTgt, popNext, rdAbs, wrAbs, freeAbs;

  always_comb begin
    loadCycle = tagLoadEn | topLoadEn;
    pushTgt   = topQ - PTR_W'(1);
    popNext   = topQ + PTR_W'(1);
    rdAbs     = topQ + rdIdx;
    wrAbs     = topQ + wrIdx;
    freeAbs   = topQ + freeIdx;
    pushOk    = pushEn && !loadCycle && (tagQ[pushTgt] == TAG_EMPTY);
    ovfSet    = pushEn && !loadCycle && (tagQ[pushTgt] != TAG_EMPTY);
    doPop     = popEn  && !pushEn && !loadCycle;
    doWr      = wrEn   && !pushEn && !popEn && !loadCycle;
    doFree    = freeEn && !pushEn && !popEn && !wrEn && !loadCycle;
    unfSet    = (rdEn && tagQ[rdAbs] == TAG_EMPTY) ||
                (doPop && tagQ[topQ] == TAG_EMPTY);
    strb.wrStb   = pushOk | doWr;
    strb.selPush = pushOk;
    strb.wrAddr  = pushOk ? pushTgt : wrAbs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ <= '0;
      for (int k = 0; k < NREG; k++) tagQ[k] <= TAG_EMPTY;
      ovfQ <= 1'b0;
      unfQ <= 1'b0;
    end else begin
      if (topLoadEn)   topQ <= topLoadData;
      else if (pushOk) topQ <= pushTgt;
      else if (doPop)  topQ <= popNext;

      if (tagLoadEn) begin
        for (int k = 0; k < NREG; k++) tagQ[k] <= tagE'(tagLoadData[2*k +: 2]);
      end else if (pushOk) tagQ[pushTgt] <= classify(pushData);
      else if (doPop)      tagQ[topQ]    <= TAG_EMPTY;
      else if (doWr)       tagQ[wrAbs]   <= classify(wrData);
      else if (doFree)     tagQ[freeAbs] <= TAG_EMPTY;

      ovfQ <= ovfSet | (ovfQ & ~flagClr);
      unfQ <= unfSet | (unfQ & ~flagClr);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gTagPack
    assign tagWord[2*g +: 2] = tagQ[g];
  end
endmodule

// File: rtl/tagStackData.sv
module tagStackData
  import tagStackPkg::*;
(
  input  logic             clk,
  input  dpStrobeT         strb,
  input  logic [VAL_W-1:0] pushData,
  input  logic [VAL_W-1:0] wrData,
  input  logic [PTR_W-1:0] topQ,
  input  logic [PTR_W-1:0] rdIdx,
  output logic [VAL_W-1:0] rdData,
  output logic [VAL_W-1:0] popData
);
  logic [VAL_W-1:0] regQ [NREG];
  logic [PTR_W-1:0] rdAbs;

  always_ff @(posedge clk) begin
    if (strb.wrStb) regQ[strb.wrAddr] <= strb.selPush ? pushData : wrData;
  end

  always_comb begin
    rdAbs   = topQ + rdIdx;
    rdData  = regQ[rdAbs];
    popData = regQ[topQ];
  end
endmodule

// File: rtl/tagStack.sv
module tagStack
  import tagStackPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [VAL_W-1:0] pushData,
  input  logic             popEn,
  output logic [VAL_W-1:0] popData,
  input  logic             rdEn,
  input  logic [PTR_W-1:0] rdIdx,
  output logic [VAL_W-1:0] rdData,
  input  logic             wrEn,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [VAL_W-1:0] wrData,
  input  logic             freeEn,
  input  logic [PTR_W-1:0] freeIdx,
  input  logic             tagLoadEn,
  input  logic [TW_W-1:0]  tagLoadData,
  input  logic             topLoadEn,
  input  logic [PTR_W-1:0] topLoadData,
  input  logic             flagClr,
  output logic [TW_W-1:0]  tagWord,
  output logic [PTR_W-1:0] top,
  output logic             overflow,
  output logic             underflow
);
  dpStrobeT strb;

  tagStackCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData), .popEn(popEn),
    .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .freeEn(freeEn), .freeIdx(freeIdx), .tagLoadEn(tagLoadEn),
    .tagLoadData(tagLoadData), .topLoadEn(topLoadEn), .topLoadData(topLoadData),
    .flagClr(flagClr), .strb(strb), .topQ(top), .tagWord(tagWord),
    .ovfQ(overflow), .unfQ(underflow)
  );

  tagStackData u_data (
    .clk(clk), .strb(strb), .pushData(pushData), .wrData(wrData), .topQ(top),
    .rdIdx(rdIdx), .rdData(rdData), .popData(popData)
  );
endmodule

// File: rtl/tagStackChk.sv
module tagStackChk
  import tagStackPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             pushEn,
  input logic             popEn,
  input logic             tagLoadEn,
  input logic             topLoadEn,
  input logic [PTR_W-1:0] topLoadData,
  input logic             flagClr,
  input logic [TW_W-1:0]  tagWord,
  input logic [PTR_W-1:0] top,
  input logic             overflow,
  input logic             underflow
);
  function automatic logic [1:0] fld(input logic [TW_W-1:0] tw, input logic [PTR_W-1:0] idx);
    return tw[{idx, 1'b0} +: 2];
  endfunction

  logic             noLoad;
  logic [PTR_W-1:0] tgt;
  assign noLoad = !tagLoadEn && !topLoadEn;
  assign tgt    = top - PTR_W'(1);

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    pushEn && noLoad && fld(tagWord, tgt) == 2'b11 |=> top == $past(top) - PTR_W'(1)); // R3
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rstN)
    popEn && !pushEn && noLoad |=> top == $past(top) + PTR_W'(1)); // R4
  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    popEn && !pushEn && noLoad |=> fld(tagWord, $past(top)) == 2'b11); // R6
  AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pushEn && noLoad && fld(tagWord, tgt) != 2'b11 |=> overflow && $stable(top) && $stable(tagWord)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !flagClr |=> overflow); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !flagClr |=> underflow); // R10
  AST_TOP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    topLoadEn |=> top == $past(topLoadData)); // R11
endmodule

bind tagStack tagStackChk u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .tagLoadEn(tagLoadEn),
  .topLoadEn(topLoadEn), .topLoadData(topLoadData), .flagClr(flagClr),
  .tagWord(tagWord), .top(top), .overflow(overflow), .underflow(underflow)
);

// File: tb/tagStack_tb.sv
module tagStack_tb;
  localparam int CLK_P = 10;

  localparam logic [79:0] V_NORM = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_NEG  = {1'b1, 15'h4000, 64'hC000_0000_0000_0000};
  localparam logic [79:0] V_ZERO = 80'h0;
  localparam logic [79:0] V_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_DEN  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
  localparam logic [79:0] V_UNN  = {1'b0, 15'h4000, 64'h4000_0000_0000_0000};

  logic clk = 0, rstN = 0;
  logic pushEn = 0, popEn = 0, rdEn = 0, wrEn = 0, freeEn = 0;
  logic tagLoadEn = 0, topLoadEn = 0, flagClr = 0;
  logic [79:0] pushData = 0, wrData = 0, popData, rdData;
  logic [2:0]  rdIdx = 0, wrIdx = 0, freeIdx = 0, topLoadData = 0, top;
  logic [15:0] tagLoadData = 0, tagWord;
  logic overflow, underflow;
  int nChk = 0, nErr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tagStack u_dut (.*);

  task automatic chk(input string rq, input logic [79:0] act, input logic [79:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic clr();
    pushEn = 0; popEn = 0; rdEn = 0; wrEn = 0; freeEn = 0;
    tagLoadEn = 0; topLoadEn = 0; flagClr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  task automatic doReset();
    clr(); rstN = 0; tick(); tick(); rstN = 1;
  endtask

  task automatic push(input logic [79:0] v);
    pushEn = 1; pushData = v; tick();
  endtask

  task automatic readAt(input string rq, input logic [2:0] i, input logic [79:0] exp);
    rdIdx = i; #1; chk(rq, rdData, exp);
  endtask

  task automatic tReset();
    doReset();
    chk("R1 top", top, 0);
    chk("R1 tagWord", tagWord, 16'hFFFF);
    chk("R1 flags", {overflow, underflow}, 0);
  endtask

  task automatic tPushPop();
    doReset();
    push(V_NORM);
    chk("R3 top wraps to 7", top, 7);
    chk("R2 tag7 valid", tagWord, 16'h3FFF);
    readAt("R3 ST0 after push", 0, V_NORM);
    push(V_NEG);
    chk("R3 top 6", top, 6);
    popEn = 1; #1;
    chk("R4 popData", popData, V_NEG);
    tick();
    chk("R4 top after pop", top, 7);
    chk("R6 popped tag empty", tagWord, 16'h3FFF);
    popEn = 1; #1;
    chk("R4 popData second", popData, V_NORM);
    tick();
    chk("R4 top wraps to 0", top, 0);
    chk("R9 no underflow on valid pops", underflow, 0);
  endtask

  task automatic tClassify();
    doReset();
    push(V_NORM); push(V_ZERO);
    chk("R2 zero tag", tagWord, 16'h1FFF);
    push(V_INF); push(V_DEN); push(V_UNN);
    chk("R2 special tags", tagWord, 16'h1ABF);
    chk("R3 top after five", top, 3);
  endtask

  task automatic tRelRead();
    readAt("R5 ST0", 0, V_UNN);
    readAt("R5 ST2", 2, V_INF);
    readAt("R5 ST4", 4, V_NORM);
    pushEn = 1; pushData = V_NEG; rdIdx = 0; #1;
    chk("R5 read sees pre-push top", rdData, V_UNN);
    tick();
    readAt("R5 ST0 after push", 0, V_NEG);
    readAt("R5 ST5 wraps", 5, V_NORM);
    doReset();
    push(V_NORM);
    wrEn = 1; wrIdx = 1; wrData = V_ZERO; tick();
    chk("R7 write tag at reg0", tagWord, 16'h3FFD);
    readAt("R7 ST1 readback", 1, V_ZERO);
    popEn = 1; tick();
    popEn = 1; #1;
    chk("R4 pop wrapped reg0", popData, V_ZERO);
    tick();
    chk("R4 top wraps up", top, 1);
  endtask

  task automatic tFree();
    doReset();
    push(V_NORM); push(V_NEG);
    freeEn = 1; freeIdx = 1; tick();
    chk("R6 free tag", tagWord, 16'hCFFF);
    chk("R6 free keeps top", top, 6);
    tagLoadEn = 1; tagLoadData = 16'h0FFF; tick();
    readAt("R6 contents kept", 1, V_NORM);
  endtask

  task automatic tOverflow();
    doReset();
    push(V_NORM);
    topLoadEn = 1; topLoadData = 0; tick();
    push(V_NEG);
    chk("R8 overflow set", overflow, 1);
    chk("R8 top unchanged", top, 0);
    chk("R8 tags unchanged", tagWord, 16'h3FFF);
    topLoadEn = 1; topLoadData = 7; tick();
    readAt("R8 no write", 0, V_NORM);
    tick();
    chk("R10 overflow sticky", overflow, 1);
    flagClr = 1; tick();
    chk("R10 overflow cleared", overflow, 0);
  endtask

  task automatic tUnderflow();
    doReset();
    rdEn = 1; rdIdx = 3; tick();
    chk("R9 read empty", underflow, 1);
    tick();
    chk("R10 underflow sticky", underflow, 1);
    flagClr = 1; tick();
    chk("R10 underflow cleared", underflow, 0);
    popEn = 1; tick();
    chk("R9 pop empty", underflow, 1);
    chk("R9 pop empty advances", top, 1);
    flagClr = 1; rdEn = 1; rdIdx = 0; tick();
    chk("R10 set wins over clear", underflow, 1);
  endtask

  task automatic tLoads();
    doReset();
    tagLoadEn = 1; tagLoadData = 16'h1234; pushEn = 1; pushData = V_NORM; tick();
    chk("R11 tag load", tagWord, 16'h1234);
    chk("R11 push ignored", top, 0);
    topLoadEn = 1; topLoadData = 5; popEn = 1; tick();
    chk("R11 top load", top, 5);
    chk("R11 pop ignored", tagWord, 16'h1234);
    chk("R11 no flags", {overflow, underflow}, 0);
  endtask

  task automatic tPriority();
    doReset();
    push(V_NORM);
    pushEn = 1; pushData = V_ZERO; popEn = 1; wrEn = 1; wrIdx = 0; wrData = V_INF;
    freeEn = 1; freeIdx = 0; tick();
    chk("R12 push wins top", top, 6);
    chk("R12 push wins tags", tagWord, 16'h1FFF);
    popEn = 1; wrEn = 1; wrIdx = 0; wrData = V_INF; freeEn = 1; freeIdx = 1; #1;
    chk("R12 pop data", popData, V_ZERO);
    tick();
    chk("R12 pop wins top", top, 7);
    chk("R12 pop wins tags", tagWord, 16'h3FFF);
    wrEn = 1; wrIdx = 0; wrData = V_INF; freeEn = 1; freeIdx = 0; tick();
    chk("R12 write beats free", tagWord, 16'hBFFF);
  endtask

  initial begin
    tReset();
    tPushPop();
    tClassify();
    tRelRead();
    tFree();
    tOverflow();
    tUnderflow();
    tLoads();
    tPriority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule